// File: doc/BRIEF.md
# Load Dependence and Stall Duration Predictor

This block is a direct-mapped table of per-load predictions. It is indexed by a slice of the load's program counter. Each entry holds a wait flag and a predicted stall length in cycles. The wait flag says that the load has been seen waiting on an older store whose address was still unknown. A fetch-side gating policy looks up each fetched load. When the flag is set, it can hold the thread back and release it a few cycles before the predicted stall ends.

The back end trains the table when a load retires or resolves. It reports whether the load really waited on a store and how many cycles the wait lasted. Each entry keeps its last four observed stall lengths and their running sum. The stored estimate follows one of three policies, chosen per training event: the largest length seen, the latest length, or the mean of the last four. A one-cycle clear wipes the whole table. A small decay state machine also forgets all wait flags at a programmable interval. It has three states. IDLE is held while the period is zero. COUNT counts cycles, and leaves for FLUSH when the count reaches the period, or for IDLE when the period becomes zero. FLUSH lasts one cycle and returns to COUNT, or to IDLE if the period is zero.

Top module: `mdep_delay_predictor`

## Requirements
- R1: The entry is selected by PC bits [7:2]. Two PCs equal in those bits share one entry, and bits outside that slice have no effect.
- R2: rsp_valid_o is high exactly in the cycle after a cycle with lk_valid_i high, and low otherwise. The returned wait flag and delay reflect any training write made in the request cycle (write first).
- R3: A training event with trn_waited_i=1 and a nonzero trn_delay_i sets the entry's wait flag.
- R4: A training event with trn_waited_i=0 or with trn_delay_i=0 clears the wait flag. It leaves the stored delay and the four-deep history unchanged.
- R5: Policy encoding is taken from policy_i in the training cycle: 0 = maximum, 1 = latest, 2 = mean, 3 = same as latest. Under maximum, the new delay is the larger of the stored delay and the observation.
- R6: Under the latest policy, the stored delay becomes the observed delay.
- R7: Every dependence training event shifts the observation into the entry's four-deep history, whatever the policy. The history is all zeros after reset or clear. Under the mean policy, the stored delay is floor(sum of the four history values / 4), with the new observation counted in.
- R8: Observed delays above 255 are saturated to 255 before any policy or history use.
- R9: clr_i high for one cycle zeroes every wait flag, delay and history. It overrides a training event in the same cycle.
- R10: With decay_period_i = P > 0, the state machine spends P cycles in COUNT and then one in FLUSH. The FLUSH cycle clears all wait flags but keeps delays and histories. With P = 0 the machine stays in IDLE and no flag is ever cleared by decay.
- R11: After reset every entry reads wait 0 and delay 0, and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the whole table |
| policy_i | input | 2 | Delay update policy for the current training event |
| decay_period_i | input | 16 | Cycles between wait-flag flushes, 0 disables |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | PC of the looked-up load |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_wait_o | output | 1 | Predicted wait-on-store flag |
| rsp_delay_o | output | 8 | Predicted stall duration in cycles |
| trn_valid_i | input | 1 | Training event |
| trn_pc_i | input | 32 | PC of the trained load |
| trn_waited_i | input | 1 | Load actually waited on a store |
| trn_delay_i | input | 12 | Observed stall duration in cycles |

## Verification
The hardest state to reach from the ports is a history that was built under one policy and is then read through another. Stale slots also linger after flag-only updates. Neither shows up in the stored delay until a later mean-policy event exposes it.

The stimulus fills entries with maximum- and latest-policy events, interleaves zero-delay and not-waited events, and then trains the mean policy on the same entries. The expected averages depend on the exact contents of the four slots and on the position of the write pointer. Decay is checked by holding a long idle stretch first with the period at zero and then with a small period, so the result does not depend on where the FLUSH cycle falls.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    typedef enum logic [1:0] {
        POL_MAX  = 2'd0,
        POL_LAST = 2'd1,
        POL_AVG  = 2'd2,
        POL_RSVD = 2'd3
    } delay_pol_e;

    typedef enum logic [1:0] {
        DK_IDLE  = 2'd0,
        DK_COUNT = 2'd1,
        DK_FLUSH = 2'd2
    } decay_st_e;

endpackage

// File: rtl/mdp_decay_timer.sv
module mdp_decay_timer
    import mdp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             flush_o
);

    decay_st_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DK_IDLE;
            cnt_q <= '0;
        end else if (clr_i) begin
            st_q  <= DK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        unique case (st_q)
            DK_IDLE: begin
                if (period_i != '0) st_d = DK_COUNT;
            end
            DK_COUNT: begin
                if (period_i == '0) begin
                    st_d = DK_IDLE;
                end else if (cnt_q >= period_i - CNT_W'(1)) begin
                    st_d = DK_FLUSH;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            DK_FLUSH: begin
                st_d = (period_i == '0) ? DK_IDLE : DK_COUNT;
            end
            default: st_d = DK_IDLE;
        endcase
    end

    always_comb begin
        flush_o = (st_q == DK_FLUSH);
    end

    // R10
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DK_FLUSH) |=> (st_q != DK_FLUSH));

    // R10
    idle_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> !flush_o);

endmodule

// File: rtl/mdp_delay_calc.sv
module mdp_delay_calc
    import mdp_pkg::*;
#(
    parameter int DELAY_W = 8,
    parameter int OBS_W   = 12,
    parameter int HIST_N  = 4,
    localparam int PTR_W  = $clog2(HIST_N),
    localparam int SUM_W  = DELAY_W + PTR_W
) (
    input  delay_pol_e         pol_i,
    input  logic [DELAY_W-1:0] old_delay_i,
    input  logic [SUM_W-1:0]   old_sum_i,
    input  logic [DELAY_W-1:0] oldest_i,
    input  logic [OBS_W-1:0]   obs_i,
    output logic [DELAY_W-1:0] obs_sat_o,
    output logic [DELAY_W-1:0] new_delay_o,
    output logic [SUM_W-1:0]   new_sum_o
);

    localparam logic [OBS_W-1:0] SAT_LIM = OBS_W'({DELAY_W{1'b1}});

    logic [DELAY_W-1:0] avg;

    always_comb begin
        obs_sat_o = (obs_i > SAT_LIM) ? {DELAY_W{1'b1}} : obs_i[DELAY_W-1:0];
        new_sum_o = old_sum_i - SUM_W'(oldest_i) + SUM_W'(obs_sat_o);
        avg       = new_sum_o[SUM_W-1:PTR_W];
        unique case (pol_i)
            POL_MAX:  new_delay_o = (obs_sat_o > old_delay_i) ? obs_sat_o : old_delay_i;
            POL_AVG:  new_delay_o = avg;
            POL_LAST,
            POL_RSVD: new_delay_o = obs_sat_o;
            default:  new_delay_o = obs_sat_o;
        endcase
    end

endmodule

// File: rtl/mdp_entry.sv
module mdp_entry #(
    parameter int DELAY_W = 8,
    parameter int HIST_N  = 4,
    localparam int PTR_W  = $clog2(HIST_N),
    localparam int SUM_W  = DELAY_W + PTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               flush_i,
    input  logic               dep_wr_i,
    input  logic               nodep_wr_i,
    input  logic [DELAY_W-1:0] obs_i,
    input  logic [DELAY_W-1:0] new_delay_i,
    input  logic [SUM_W-1:0]   new_sum_i,
    output logic               pred_o,
    output logic [DELAY_W-1:0] delay_o,
    output logic [SUM_W-1:0]   sum_o,
    output logic [DELAY_W-1:0] oldest_o
);

    logic               pred_q;
    logic [DELAY_W-1:0] delay_q;
    logic [SUM_W-1:0]   sum_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [DELAY_W-1:0] hist_q [HIST_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q  <= 1'b0;
            delay_q <= '0;
            sum_q   <= '0;
            ptr_q   <= '0;
            for (int k = 0; k < HIST_N; k++) hist_q[k] <= '0;
        end else if (clr_i) begin
            pred_q  <= 1'b0;
            delay_q <= '0;
            sum_q   <= '0;
            ptr_q   <= '0;
            for (int k = 0; k < HIST_N; k++) hist_q[k] <= '0;
        end else if (dep_wr_i) begin
            pred_q        <= 1'b1;
            delay_q       <= new_delay_i;
            sum_q         <= new_sum_i;
            hist_q[ptr_q] <= obs_i;
            ptr_q         <= ptr_q + PTR_W'(1);
        end else if (nodep_wr_i || flush_i) begin
            pred_q <= 1'b0;
        end
    end

    assign pred_o   = pred_q;
    assign delay_o  = delay_q;
    assign sum_o    = sum_q;
    assign oldest_o = hist_q[ptr_q];

endmodule

// File: rtl/mdep_delay_predictor.sv
module mdep_delay_predictor
    import mdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int PC_OFS  = 2,
    parameter int DELAY_W = 8,
    parameter int OBS_W   = 12,
    parameter int HIST_N  = 4,
    parameter int DECAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [1:0]         policy_i,
    input  logic [DECAY_W-1:0] decay_period_i,
    input  logic               lk_valid_i,
    input  logic [PC_W-1:0]    lk_pc_i,
    output logic               rsp_valid_o,
    output logic               rsp_wait_o,
    output logic [DELAY_W-1:0] rsp_delay_o,
    input  logic               trn_valid_i,
    input  logic [PC_W-1:0]    trn_pc_i,
    input  logic               trn_waited_i,
    input  logic [OBS_W-1:0]   trn_delay_i
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int PTR_W  = $clog2(HIST_N);
    localparam int SUM_W  = DELAY_W + PTR_W;
    localparam int IDX_LO = PC_OFS;
    localparam int IDX_HI = PC_OFS + IDX_W - 1;

    logic [IDX_W-1:0]   lk_idx, trn_idx, lk_idx_q;
    logic               rsp_valid_q;
    logic               trn_dep, trn_nodep, flush;
    logic [ENTRIES-1:0] pred_vec;
    logic [DELAY_W-1:0] delay_arr  [ENTRIES];
    logic [SUM_W-1:0]   sum_arr    [ENTRIES];
    logic [DELAY_W-1:0] oldest_arr [ENTRIES];
    logic [DELAY_W-1:0] obs_sat, new_delay;
    logic [SUM_W-1:0]   new_sum;
    logic               unused_pc_bits;

    assign lk_idx    = lk_pc_i[IDX_HI:IDX_LO];
    assign trn_idx   = trn_pc_i[IDX_HI:IDX_LO];
    assign trn_dep   = trn_valid_i && trn_waited_i && (trn_delay_i != '0);
    assign trn_nodep = trn_valid_i && !trn_dep;

    assign unused_pc_bits = ^{lk_pc_i[PC_W-1:IDX_HI+1], lk_pc_i[PC_OFS-1:0],
                              trn_pc_i[PC_W-1:IDX_HI+1], trn_pc_i[PC_OFS-1:0]};

    mdp_decay_timer #(.CNT_W(DECAY_W)) u_decay (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .period_i (decay_period_i),
        .flush_o  (flush)
    );

    mdp_delay_calc #(.DELAY_W(DELAY_W), .OBS_W(OBS_W), .HIST_N(HIST_N)) u_calc (
        .pol_i       (delay_pol_e'(policy_i)),
        .old_delay_i (delay_arr[trn_idx]),
        .old_sum_i   (sum_arr[trn_idx]),
        .oldest_i    (oldest_arr[trn_idx]),
        .obs_i       (trn_delay_i),
        .obs_sat_o   (obs_sat),
        .new_delay_o (new_delay),
        .new_sum_o   (new_sum)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic hit;
        assign hit = (trn_idx == IDX_W'(i));

        mdp_entry #(.DELAY_W(DELAY_W), .HIST_N(HIST_N)) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_i       (clr_i),
            .flush_i     (flush),
            .dep_wr_i    (hit && trn_dep),
            .nodep_wr_i  (hit && trn_nodep),
            .obs_i       (obs_sat),
            .new_delay_i (new_delay),
            .new_sum_i   (new_sum),
            .pred_o      (pred_vec[i]),
            .delay_o     (delay_arr[i]),
            .sum_o       (sum_arr[i]),
            .oldest_o    (oldest_arr[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            lk_idx_q    <= '0;
        end else begin
            rsp_valid_q <= lk_valid_i;
            if (lk_valid_i) lk_idx_q <= lk_idx;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_wait_o  = rsp_valid_q && pred_vec[lk_idx_q];
    assign rsp_delay_o = rsp_valid_q ? delay_arr[lk_idx_q] : '0;

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> rsp_valid_o);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !rsp_valid_o);

    // R3
    dep_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_dep && !clr_i) |=> pred_vec[$past(trn_idx)]);

    // R4
    nodep_keeps_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_nodep && !clr_i) |=>
            (!pred_vec[$past(trn_idx)] &&
             delay_arr[$past(trn_idx)] == $past(delay_arr[trn_idx])));

    // R5
    max_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_dep && !clr_i && policy_i == 2'd0) |=>
            (delay_arr[$past(trn_idx)] >= $past(delay_arr[trn_idx])));

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pred_vec == '0));

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !clr_i && !trn_valid_i) |=> (pred_vec == '0));

endmodule

// File: tb/test_mdep_delay_predictor.sv
`timescale 1ns/1ps
module test_mdep_delay_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr;
    logic [1:0]  policy;
    logic [15:0] period;
    logic        lk_valid;
    logic [31:0] lk_pc;
    logic        rsp_valid, rsp_wait;
    logic [7:0]  rsp_delay;
    logic        trn_valid;
    logic [31:0] trn_pc;
    logic        trn_waited;
    logic [11:0] trn_delay;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] PC_A = 32'h104;
    localparam logic [31:0] PC_B = 32'h108;
    localparam logic [31:0] PC_C = 32'h10C;
    localparam logic [31:0] PC_D = 32'h110;
    localparam logic [31:0] PC_A_ALIAS = 32'h204;

    always #10 clk = ~clk;

    mdep_delay_predictor i_mdep_delay_predictor (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (clr),
        .policy_i       (policy),
        .decay_period_i (period),
        .lk_valid_i     (lk_valid),
        .lk_pc_i        (lk_pc),
        .rsp_valid_o    (rsp_valid),
        .rsp_wait_o     (rsp_wait),
        .rsp_delay_o    (rsp_delay),
        .trn_valid_i    (trn_valid),
        .trn_pc_i       (trn_pc),
        .trn_waited_i   (trn_waited),
        .trn_delay_i    (trn_delay)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic w, input int d, input logic [1:0] pol);
        @(negedge clk);
        trn_valid = 1'b1; trn_pc = pc; trn_waited = w; trn_delay = 12'(d); policy = pol;
        @(negedge clk);
        trn_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [31:0] pc, input int w, input int d);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " valid"}, int'(rsp_valid), 1);
        chk({tag, " wait"},  int'(rsp_wait), w);
        chk({tag, " delay"}, int'(rsp_delay), d);
    endtask

    task automatic t_reset();
        chk("R11 valid low after reset", int'(rsp_valid), 0);
        expect_rsp("R11 reset entry", PC_A, 0, 0);
    endtask

    task automatic t_last();
        train(PC_A, 1'b1, 20, 2'd1);
        expect_rsp("R3 R6 last 20", PC_A, 1, 20);
        train(PC_A, 1'b1, 7, 2'd1);
        expect_rsp("R6 last 7", PC_A, 1, 7);
        train(PC_A, 1'b1, 9, 2'd3);
        expect_rsp("R5 code3 as last", PC_A, 1, 9);
    endtask

    task automatic t_max();
        train(PC_B, 1'b1, 30, 2'd0);
        expect_rsp("R5 max 30", PC_B, 1, 30);
        train(PC_B, 1'b1, 10, 2'd0);
        expect_rsp("R5 max keeps 30", PC_B, 1, 30);
        train(PC_B, 1'b1, 50, 2'd0);
        expect_rsp("R5 max grows 50", PC_B, 1, 50);
    endtask

    task automatic t_avg();
        train(PC_C, 1'b1, 40, 2'd2);
        expect_rsp("R7 avg 10", PC_C, 1, 10);
        train(PC_C, 1'b1, 80, 2'd2);
        expect_rsp("R7 avg 30", PC_C, 1, 30);
        train(PC_C, 1'b1, 20, 2'd2);
        expect_rsp("R7 avg 35", PC_C, 1, 35);
        train(PC_C, 1'b1, 60, 2'd2);
        expect_rsp("R7 avg 50", PC_C, 1, 50);
        train(PC_C, 1'b1, 100, 2'd2);
        expect_rsp("R7 avg window 65", PC_C, 1, 65);
        // history of B was built under max policy: 30,10,50,0
        train(PC_B, 1'b1, 70, 2'd2);
        expect_rsp("R7 shared history 40", PC_B, 1, 40);
    endtask

    task automatic t_sat();
        train(PC_D, 1'b1, 300, 2'd1);
        expect_rsp("R8 sat last", PC_D, 1, 255);
        train(PC_D, 1'b1, 4095, 2'd0);
        expect_rsp("R8 sat max", PC_D, 1, 255);
    endtask

    task automatic t_nodep();
        train(PC_A, 1'b1, 0, 2'd1);
        expect_rsp("R4 zero delay", PC_A, 0, 9);
        train(PC_A, 1'b0, 33, 2'd1);
        expect_rsp("R4 not waited", PC_A, 0, 9);
        // A history 20,7,9,0 untouched by the two events above
        train(PC_A, 1'b1, 40, 2'd2);
        expect_rsp("R4 history kept", PC_A, 1, 19);
    endtask

    task automatic t_alias();
        expect_rsp("R1 alias read", PC_A_ALIAS, 1, 19);
        train(PC_A_ALIAS, 1'b1, 5, 2'd1);
        expect_rsp("R1 alias write", PC_A, 1, 5);
        expect_rsp("R1 neighbour intact", PC_B, 1, 40);
    endtask

    task automatic t_write_first();
        @(negedge clk);
        trn_valid = 1'b1; trn_pc = PC_B; trn_waited = 1'b1; trn_delay = 12'd90; policy = 2'd0;
        lk_valid = 1'b1; lk_pc = PC_B;
        @(negedge clk);
        trn_valid = 1'b0; lk_valid = 1'b0;
        chk("R2 write first valid", int'(rsp_valid), 1);
        chk("R2 write first wait", int'(rsp_wait), 1);
        chk("R2 write first delay", int'(rsp_delay), 90);
        @(negedge clk);
        chk("R2 valid single cycle", int'(rsp_valid), 0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr = 1'b1;
        trn_valid = 1'b1; trn_pc = PC_A; trn_waited = 1'b1; trn_delay = 12'd77; policy = 2'd1;
        @(negedge clk);
        clr = 1'b0; trn_valid = 1'b0;
        expect_rsp("R9 clear beats train", PC_A, 0, 0);
        expect_rsp("R9 clear other", PC_B, 0, 0);
        train(PC_C, 1'b1, 40, 2'd2);
        expect_rsp("R9 history zeroed", PC_C, 1, 10);
    endtask

    task automatic t_decay();
        train(PC_B, 1'b1, 12, 2'd1);
        repeat (30) @(negedge clk);
        expect_rsp("R10 period zero keeps", PC_B, 1, 12);
        period = 16'd8;
        repeat (30) @(negedge clk);
        expect_rsp("R10 flush clears flag", PC_B, 0, 12);
        period = 16'd0;
        repeat (3) @(negedge clk);
        train(PC_B, 1'b1, 14, 2'd1);
        repeat (20) @(negedge clk);
        expect_rsp("R10 disabled again", PC_B, 1, 14);
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0; policy = 2'd0; period = 16'd0;
        lk_valid = 1'b0; lk_pc = '0;
        trn_valid = 1'b0; trn_pc = '0; trn_waited = 1'b0; trn_delay = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_last();
        t_max();
        t_avg();
        t_sat();
        t_nodep();
        t_alias();
        t_write_first();
        t_clear();
        t_decay();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule